// File: doc/BRIEF.md
# Resolution-Configurable Conversion Sequencer

This block paces repeated measurements of a sensor and publishes each finished one to a result register. It is meant to sit between an abstract measurement source and the threshold and alarm logic of a temperature monitor. The sensor is modelled as a 16-bit signed sample that the block takes at the close of each conversion. The block then rounds that sample down to the chosen resolution and stores it as a left-justified two's-complement word.

A 2-bit resolution code sets both the precision and the conversion length. The coarsest setting has the base period, and each finer step doubles it. Conversions follow one another with no gap while the shutdown input is low. Raising shutdown does not cut a conversion short: the conversion in flight runs to its end and is stored, and then the block goes quiet. Each store is marked by a single-cycle done pulse for downstream consumers.

Top module: `conv_sequencer`

## Requirements
- R1: With shutdown low, the first conversion starts at the first rising edge after reset is released. The first conv_done goes high after the (P+1)-th such edge, where P is the period of the resolution code present at that first edge.
- R2: Resolution codes 0, 1, 2 and 3 keep the top 9, 10, 11 or 12 bits of the sample and clear every bit below them. This truncates toward minus infinity. In degrees, the kept bits give steps of 0.5, 0.25, 0.125 and 0.0625, since bit 4 weighs 1/16 degree.
- R3: A conversion lasts BASE_CYCLES × 2^code clock cycles. While shutdown stays low, the rising edges of conv_done are spaced by exactly that period.
- R4: After reset, temp_result is 0 and conv_done is 0. Bits 3..0 of temp_result always read 0.
- R5: The stored result is the quantised sensor_sample present at the rising edge that raises conv_done.
- R6: temp_result changes only in a cycle in which conv_done is high. Between stores it holds its value whatever the sensor input does.
- R7: If shutdown is high at the edge that ends a conversion, that result is still stored and signalled. No further conv_done then occurs while shutdown stays high.
- R8: The resolution code is taken at the edge that starts a conversion. Changing it during the conversion alters neither that conversion's length nor its quantisation.
- R9: conv_done is high for exactly one cycle per stored result.
- R10: While the block is idle, the first rising edge that sees shutdown low starts a conversion. conv_done then follows P edges later, where P is the period of the code sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Stop after the conversion in progress; hold idle while high |
| res_sel | input | 2 | Resolution code, 0 = 9 bits up to 3 = 12 bits |
| sensor_sample | input | 16 | Signed sensor value, sampled at the end of a conversion |
| temp_result | output | 16 | Last completed result, left-justified two's complement |
| conv_done | output | 1 | One-cycle pulse when temp_result is updated |

## Verification
The bench builds the block with BASE_CYCLES set to 3 and keeps the defaults for a 16-bit word, 4 padding bits and 4 resolution steps. That makes the four conversion lengths 3, 6, 12 and 24 cycles. The short periods mean every length recurs many times in a short run. They also let resolution changes, shutdown requests and sensor changes land at early, middle and final cycles of a conversion, including the final edge itself where shutdown decides between restart and idle.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // cycles taken by a conversion at resolution step idx
   function automatic int unsigned period_cycles(int unsigned base, int unsigned idx);
      return base << idx;
   endfunction

endpackage

// File: rtl/conv_seq_timer.sv
module conv_seq_timer #(
   parameter int unsigned BASE_CYCLES = 1000,
   parameter int unsigned STEPS       = 4,
   parameter int unsigned CODE_W      = 2,
   parameter int unsigned CNT_W       = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   output logic              last
);
   import conv_seq_pkg::*;

   logic [CNT_W-1:0]  reload_tab [STEPS];
   logic [CNT_W-1:0]  cnt_q;
   logic [CODE_W-1:0] code_c;

   for (genvar g = 0; g < STEPS; g++) begin : g_reload
      assign reload_tab[g] = CNT_W'(period_cycles(BASE_CYCLES, g) - 1);
   end

   always_comb begin
      code_c = (32'(code) < STEPS) ? code : CODE_W'(STEPS - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= reload_tab[code_c];
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/conv_seq_quant.sv
module conv_seq_quant #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned PAD_BITS = 4,
   parameter int unsigned STEPS    = 4,
   parameter int unsigned CODE_W   = 2
) (
   input  logic [CODE_W-1:0] code,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] quant
);
   localparam int unsigned MIN_BITS = DATA_W - PAD_BITS - (STEPS - 1);

   logic [DATA_W-1:0] keep_tab [STEPS];
   logic [CODE_W-1:0] code_c;

   // step g keeps the top MIN_BITS+g bits of the word
   for (genvar g = 0; g < STEPS; g++) begin : g_mask
      localparam int unsigned ZEROS = DATA_W - MIN_BITS - g;
      assign keep_tab[g] = {DATA_W{1'b1}} << ZEROS;
   end

   always_comb begin
      code_c = (32'(code) < STEPS) ? code : CODE_W'(STEPS - 1);
      quant  = raw & keep_tab[code_c];
   end

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl #(
   parameter int unsigned CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shutdown,
   input  logic [CODE_W-1:0] res_sel,
   input  logic              last,
   output logic              load,
   output logic              capture,
   output logic [CODE_W-1:0] res_lat
);
   import conv_seq_pkg::*;

   seq_state_e state_q, state_d;
   logic       start_idle;

   always_comb begin
      start_idle = (state_q == SEQ_IDLE) && !shutdown;
      capture    = (state_q == SEQ_RUN) && last;
      load       = start_idle || (capture && !shutdown);
      state_d    = state_q;
      if (start_idle) begin
         state_d = SEQ_RUN;
      end else if (capture && shutdown) begin
         state_d = SEQ_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         res_lat <= '0;
      end else begin
         state_q <= state_d;
         if (load) begin
            res_lat <= res_sel;
         end
      end
   end

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
   parameter int unsigned BASE_CYCLES = 1000,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned PAD_BITS    = 4,
   parameter int unsigned STEPS       = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          shutdown,
   input  logic [$clog2(STEPS)-1:0]      res_sel,
   input  logic [DATA_W-1:0]             sensor_sample,
   output logic [DATA_W-1:0]             temp_result,
   output logic                          conv_done
);
   localparam int unsigned CODE_W   = $clog2(STEPS);
   localparam int unsigned MAX_PER  = BASE_CYCLES << (STEPS - 1);
   localparam int unsigned CNT_W    = $clog2(MAX_PER);
   localparam int unsigned MIN_BITS = DATA_W - PAD_BITS - (STEPS - 1);

   if (STEPS < 2) begin : g_bad_steps
      $error("conv_sequencer: STEPS must be at least 2");
   end
   if (BASE_CYCLES < 2) begin : g_bad_base
      $error("conv_sequencer: BASE_CYCLES must be at least 2");
   end
   if (PAD_BITS + STEPS + 1 > DATA_W) begin : g_bad_width
      $error("conv_sequencer: DATA_W too small for PAD_BITS and STEPS");
   end
   if (MIN_BITS < 2) begin : g_bad_min
      $error("conv_sequencer: coarsest resolution under 2 bits");
   end

   logic              load;
   logic              capture;
   logic              last;
   logic [CODE_W-1:0] res_lat;
   logic [DATA_W-1:0] quant;

   conv_seq_ctrl #(
      .CODE_W(CODE_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .shutdown (shutdown),
      .res_sel  (res_sel),
      .last     (last),
      .load     (load),
      .capture  (capture),
      .res_lat  (res_lat)
   );

   conv_seq_timer #(
      .BASE_CYCLES(BASE_CYCLES),
      .STEPS      (STEPS),
      .CODE_W     (CODE_W),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .code  (res_sel),
      .last  (last)
   );

   conv_seq_quant #(
      .DATA_W  (DATA_W),
      .PAD_BITS(PAD_BITS),
      .STEPS   (STEPS),
      .CODE_W  (CODE_W)
   ) u_quant (
      .code  (res_lat),
      .raw   (sensor_sample),
      .quant (quant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         temp_result <= '0;
         conv_done   <= 1'b0;
      end else begin
         conv_done <= capture;
         if (capture) begin
            temp_result <= quant;
         end
      end
   end

endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
   parameter int unsigned BASE_CYCLES = 1000,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned PAD_BITS    = 4,
   parameter int unsigned STEPS       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shutdown,
   input logic [DATA_W-1:0] sensor_sample,
   input logic [DATA_W-1:0] temp_result,
   input logic              conv_done
);
   localparam int unsigned MIN_BITS = DATA_W - PAD_BITS - (STEPS - 1);
   localparam int unsigned GAP_W    = $clog2(BASE_CYCLES << (STEPS - 1)) + 2;
   localparam logic [DATA_W-1:0] TOP_MASK = {DATA_W{1'b1}} << (DATA_W - MIN_BITS);
   localparam logic [GAP_W-1:0]  GAP_MAX  = {GAP_W{1'b1}};

   logic [GAP_W-1:0] gap_cnt;
   logic             seen_done;
   logic             sd_d;
   logic             sd_acc;
   logic             idle_hold;
   logic             gap_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt   <= '0;
         seen_done <= 1'b0;
         sd_d      <= 1'b0;
         sd_acc    <= 1'b0;
         idle_hold <= 1'b0;
      end else begin
         sd_d      <= shutdown;
         seen_done <= seen_done | conv_done;
         if (conv_done) begin
            gap_cnt   <= GAP_W'(1);
            sd_acc    <= sd_d;
            idle_hold <= sd_d;
         end else begin
            if (gap_cnt != GAP_MAX) begin
               gap_cnt <= gap_cnt + 1'b1;
            end
            sd_acc    <= sd_acc | sd_d;
            idle_hold <= idle_hold & shutdown;
         end
      end
   end

   always_comb begin
      gap_ok = 1'b0;
      for (int g = 0; g < STEPS; g++) begin
         if (32'(gap_cnt) == (BASE_CYCLES << g)) begin
            gap_ok = 1'b1;
         end
      end
   end

   // R4: padding bits never set
   p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_result & ~({DATA_W{1'b1}} << PAD_BITS)) == '0);

   // R6: result only moves alongside a done pulse
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |-> $stable(temp_result));

   // R9: done is a single-cycle pulse
   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> !conv_done);

   // R5: stored word carries the sample seen at the storing edge
   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> ((temp_result & TOP_MASK) == ($past(sensor_sample) & TOP_MASK)));

   // R3: back-to-back spacing is one of the legal periods
   p_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && seen_done && !sd_acc) |-> gap_ok);

   // R7: no further result while shutdown is held after a stop
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idle_hold |-> !conv_done);

endmodule

bind conv_sequencer conv_sequencer_chk #(
   .BASE_CYCLES(BASE_CYCLES),
   .DATA_W     (DATA_W),
   .PAD_BITS   (PAD_BITS),
   .STEPS      (STEPS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .shutdown     (shutdown),
   .sensor_sample(sensor_sample),
   .temp_result  (temp_result),
   .conv_done    (conv_done)
);

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        shutdown = 1'b0;
   logic [1:0]  res_sel = 2'd0;
   logic [15:0] sensor = 16'h1910;
   logic [15:0] temp_result;
   logic        conv_done;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    fin = 1'b0;
   string phase = "R4";

   // behavioural reference state
   bit          m_run = 1'b0;
   int          m_left = 0;
   int          m_res = 0;
   logic [15:0] m_result = 16'h0000;
   logic        m_done = 1'b0;

   conv_sequencer #(
      .BASE_CYCLES(BASE)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .shutdown     (shutdown),
      .res_sel      (res_sel),
      .sensor_sample(sensor),
      .temp_result  (temp_result),
      .conv_done    (conv_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] ref_quant(logic [15:0] v, int res);
      int zeros;
      int low;
      zeros = 16 - (9 + res);
      low   = (1 << zeros) - 1;
      return v & ~16'(low);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 1'b0; m_left = 0; m_res = 0; m_result = 16'h0000; m_done = 1'b0;
      end else begin
         m_done = 1'b0;
         if (!m_run) begin
            if (!shutdown) begin
               m_run = 1'b1; m_res = int'(res_sel); m_left = BASE << m_res;
            end
         end else begin
            m_left = m_left - 1;
            if (m_left == 0) begin
               m_result = ref_quant(sensor, m_res);
               m_done   = 1'b1;
               if (shutdown) m_run = 1'b0;
               else begin
                  m_res = int'(res_sel); m_left = BASE << m_res;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!fin) begin
         n_cmp++;
         if (temp_result !== m_result || conv_done !== m_done) begin
            n_bad++;
            $display("FAIL %s: result=%h done=%b expected result=%h done=%b",
                     phase, temp_result, conv_done, m_result, m_done);
         end
      end
   end

   task automatic wait_cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      wait_cycles(3);                      // R4 reset values checked each cycle
      rst_n = 1'b1;
      phase = "R1";  wait_cycles(10);
      phase = "R2";
      for (int c = 0; c < 4; c++) begin
         res_sel = 2'(c);
         sensor  = (c % 2 == 0) ? 16'hf5e3 : 16'h0a2f;
         wait_cycles(30);
      end
      phase = "R5";  res_sel = 2'd3;
      for (int k = 0; k < 8; k++) begin
         sensor = 16'(16'he6f7 + k * 16'h0111);
         wait_cycles(7);
      end
      phase = "R6";  res_sel = 2'd1;
      for (int k = 0; k < 60; k++) begin
         sensor = 16'(sensor * 13 + 16'h3b7);
         wait_cycles(1);
      end
      phase = "R8";
      for (int k = 0; k < 16; k++) begin
         res_sel = 2'(k * 3);
         sensor  = 16'(sensor * 7 + 16'h1235);
         wait_cycles(5);
      end
      phase = "R7";  res_sel = 2'd2; wait_cycles(5);
      shutdown = 1'b1; wait_cycles(40);
      phase = "R10"; res_sel = 2'd0; shutdown = 1'b0; wait_cycles(20);
      for (int k = 1; k < 6; k++) begin
         shutdown = 1'b1; wait_cycles(k);
         shutdown = 1'b0; res_sel = 2'(k); wait_cycles(k + 9);
      end
      phase = "R3";  res_sel = 2'd1; shutdown = 1'b0; wait_cycles(40);
      phase = "R9";  res_sel = 2'd0; sensor = 16'h8001; wait_cycles(30);
      fin = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!fin) begin
         fin = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL %s: watchdog expired, actual=hung expected=finished", phase);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule